// File: doc/BRIEF.md
# Count-Indexed Shifting FIFO

This block is a first-in first-out store whose occupancy lives in a single counter rather than in a pair of circular pointers. A new word is always placed just above the newest stored entry, at a slot chosen by the current count. Taking a word out always returns the bottom slot, and every remaining entry then moves down one slot, so the oldest entry always sits at the bottom.

The total area `AREA` counts the counter itself plus the data slots, so the store holds `AREA-1` words. Writes and reads each have their own strobe, and each acts once on the strobe's low-to-high transition. If both transitions fall in the same clock cycle, the read is done first and the write is then placed into the compacted store. A write that finds the store full is dropped, and the overflow flag is raised.

Top module: `shift_fifo`

## Requirements
- R1: After reset, `fill_count` is 0, `is_empty` is 1, `overflow` is 0 and `pop_data` is 0.
- R2: A write transition with `fill_count` below `AREA-1` stores `push_data` just above the newest entry, increments `fill_count` by 1 and clears `overflow`. All outputs update in the clock edge where the strobe is first seen high.
- R3: A write transition with `fill_count` equal to `AREA-1` leaves the count and the stored words unchanged and sets `overflow` to 1.
- R4: A read transition with `fill_count` above 0 loads the oldest word into `pop_data`, moves each remaining word one slot toward the bottom and decrements `fill_count` by 1.
- R5: `is_empty` is 1 exactly when `fill_count` is 0, including right after the last word is read.
- R6: A read transition with `fill_count` equal to 0 leaves `pop_data`, `fill_count` and `overflow` unchanged.
- R7: A strobe held high for several cycles acts only once. It must go low for at least one cycle before it can act again.
- R8: When read and write transitions fall in the same cycle, the read is done first and the write is then judged against the reduced count. A full store therefore accepts the write (overflow 0, count unchanged), and an empty store returns no word but stores the new one.
- R9: Words leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_strobe | input | 1 | Write trigger; acts on its rising transition |
| push_data | input | DATA_W | Word to store |
| pop_strobe | input | 1 | Read trigger; acts on its rising transition |
| pop_data | output | DATA_W | Last word read out |
| fill_count | output | $clog2(AREA) | Number of stored words |
| is_empty | output | 1 | High when no word is stored |
| overflow | output | 1 | High after a write was dropped for lack of room |

## Verification
A read and a write can fall in the same cycle. The bench raises both strobes together at three fill levels: full, partly filled and empty. In each case it compares `pop_data`, the count and both flags against a model that applies the read first and then the write. The full case shows that the write was accepted (overflow low, count unchanged). Draining the store afterwards shows that the new word landed above the compacted entries.

// File: rtl/sf_pkg.sv
package sf_pkg;
   localparam int unsigned AREA_MIN = 2;
   localparam int unsigned AREA_MAX = 2048;
endpackage

// File: rtl/sf_edge.sv
module sf_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic pulse
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign pulse = level & ~prev_q;
endmodule

// File: rtl/sf_ctrl.sv
module sf_ctrl #(
   parameter int unsigned AREA  = 8,
   parameter int unsigned CNT_W = $clog2(AREA)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_edge,
   input  logic             wr_edge,
   output logic             rd_take,
   output logic             wr_take,
   output logic [CNT_W-1:0] wr_slot,
   output logic [CNT_W-1:0] count_q,
   output logic             carry_q
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(AREA - 1);

   logic [CNT_W-1:0] after_rd;

   always_comb begin
      rd_take  = rd_edge && (count_q != '0);
      after_rd = count_q - CNT_W'(rd_take);
      wr_take  = wr_edge && (after_rd != CAP);
      wr_slot  = after_rd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         carry_q <= 1'b0;
      end else begin
         count_q <= after_rd + CNT_W'(wr_take);
         if (wr_edge) carry_q <= ~wr_take;
      end
   end
endmodule

// File: rtl/sf_store.sv
module sf_store #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned AREA   = 8,
   parameter int unsigned CNT_W  = $clog2(AREA)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_take,
   input  logic              wr_take,
   input  logic [CNT_W-1:0]  wr_slot,
   input  logic [DATA_W-1:0] wr_word,
   output logic [DATA_W-1:0] rd_word
);
   localparam int unsigned CAP = AREA - 1;

   logic [DATA_W-1:0] slot_q [CAP];

   for (genvar i = 0; i < CAP; i++) begin : g_slot
      logic [DATA_W-1:0] above;
      if (i < CAP - 1) begin : g_mid
         assign above = slot_q[i+1];
      end else begin : g_top
         // topmost slot keeps its value on a shift
         assign above = slot_q[i];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                                    slot_q[i] <= '0;
         else if (wr_take && wr_slot == CNT_W'(i))      slot_q[i] <= wr_word;
         else if (rd_take)                              slot_q[i] <= above;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rd_word <= '0;
      else if (rd_take) rd_word <= slot_q[0];
   end
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned AREA   = 8,
   localparam int unsigned CNT_W = $clog2(AREA)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_strobe,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_strobe,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  fill_count,
   output logic              is_empty,
   output logic              overflow
);
   if (AREA < sf_pkg::AREA_MIN || AREA > sf_pkg::AREA_MAX) begin : g_bad_area
      $error("shift_fifo: AREA out of range");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("shift_fifo: DATA_W must be positive");
   end

   logic             rd_edge, wr_edge, rd_take, wr_take;
   logic [CNT_W-1:0] wr_slot;

   sf_edge u_rd_edge (.clk(clk), .rst_n(rst_n), .level(pop_strobe),  .pulse(rd_edge));
   sf_edge u_wr_edge (.clk(clk), .rst_n(rst_n), .level(push_strobe), .pulse(wr_edge));

   sf_ctrl #(.AREA(AREA), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .rd_edge(rd_edge), .wr_edge(wr_edge),
      .rd_take(rd_take), .wr_take(wr_take), .wr_slot(wr_slot),
      .count_q(fill_count), .carry_q(overflow)
   );

   sf_store #(.DATA_W(DATA_W), .AREA(AREA), .CNT_W(CNT_W)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_take(rd_take), .wr_take(wr_take),
      .wr_slot(wr_slot), .wr_word(push_data), .rd_word(pop_data)
   );

   assign is_empty = (fill_count == '0);
endmodule

// File: rtl/sf_checker.sv
module sf_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned AREA   = 8,
   localparam int unsigned CNT_W = $clog2(AREA)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_edge,
   input logic              wr_edge,
   input logic [DATA_W-1:0] pop_data,
   input logic [CNT_W-1:0]  fill_count,
   input logic              is_empty,
   input logic              overflow
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(AREA - 1);

   a_r2_write_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_edge && !rd_edge && fill_count != CAP)
      |=> (fill_count == $past(fill_count) + 1'b1) && !overflow);

   a_r3_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_edge && !rd_edge && fill_count == CAP)
      |=> overflow && fill_count == CAP);

   a_r4_read_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_edge && !wr_edge && fill_count != '0)
      |=> fill_count == $past(fill_count) - 1'b1);

   a_r5_last_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_edge && !wr_edge && fill_count == CNT_W'(1)) |=> is_empty);

   a_r6_empty_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_edge && !wr_edge && fill_count == '0)
      |=> $stable(pop_data) && $stable(fill_count) && $stable(overflow));

   a_r8_both_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_edge && wr_edge && fill_count != '0)
      |=> $stable(fill_count) && !overflow);

   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_edge && !wr_edge)
      |=> $stable(fill_count) && $stable(pop_data) && $stable(overflow));

   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= CAP);
endmodule

bind shift_fifo sf_checker #(.DATA_W(DATA_W), .AREA(AREA)) chk_i (
   .clk(clk), .rst_n(rst_n), .rd_edge(rd_edge), .wr_edge(wr_edge),
   .pop_data(pop_data), .fill_count(fill_count), .is_empty(is_empty),
   .overflow(overflow)
);

// File: tb/shift_fifo_tb_top.sv
module shift_fifo_tb_top;
   localparam int unsigned DW   = 16;
   localparam int unsigned AREA = 8;
   localparam int unsigned CW   = $clog2(AREA);
   localparam int unsigned CAP  = AREA - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_strobe = 1'b0;
   logic          pop_strobe = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic [DW-1:0] pop_data;
   logic [CW-1:0] fill_count;
   logic          is_empty, overflow;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [DW-1:0] rd;
      int            cnt;
      logic          emp;
      logic          ovf;
      string         tag;
   } exp_t;

   exp_t        sb_q[$];
   logic [DW-1:0] m_store[$];
   logic [DW-1:0] m_rd = '0;
   logic          m_ovf = 1'b0;

   always #2 clk = ~clk;

   shift_fifo #(.DATA_W(DW), .AREA(AREA)) dut_i (
      .clk(clk), .rst_n(rst_n), .push_strobe(push_strobe), .push_data(push_data),
      .pop_strobe(pop_strobe), .pop_data(pop_data), .fill_count(fill_count),
      .is_empty(is_empty), .overflow(overflow)
   );

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // model: read first, then write
   task automatic model(bit r, bit w, logic [DW-1:0] d);
      if (r && m_store.size() > 0) m_rd = m_store.pop_front();
      if (w) begin
         if (m_store.size() < CAP) begin m_store.push_back(d); m_ovf = 1'b0; end
         else m_ovf = 1'b1;
      end
   endtask

   task automatic push_exp(string tag);
      exp_t e;
      e.rd = m_rd; e.cnt = m_store.size(); e.emp = (m_store.size() == 0);
      e.ovf = m_ovf; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic op(bit r, bit w, logic [DW-1:0] d, string tag, int hold);
      @(negedge clk);
      pop_strobe = r; push_strobe = w; push_data = d;
      for (int k = 0; k < hold; k++) begin
         @(posedge clk); #1;
         if (k == 0) model(r, w, d);
         push_exp(tag);
      end
      @(negedge clk); #1;
      pop_strobe = 1'b0; push_strobe = 1'b0;
   endtask

   // monitor: compare each expected record at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (pop_data !== e.rd || int'(fill_count) != e.cnt ||
                is_empty !== e.emp || overflow !== e.ovf) begin
               errors++;
               $display("FAIL %s: got rd=%h cnt=%0d emp=%b ovf=%b exp rd=%h cnt=%0d emp=%b ovf=%b",
                        e.tag, pop_data, fill_count, is_empty, overflow,
                        e.rd, e.cnt, e.emp, e.ovf);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got hang exp completion");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      checks++;
      if (pop_data !== '0 || fill_count !== '0 || is_empty !== 1'b1 || overflow !== 1'b0) begin
         errors++;
         $display("FAIL R1: got rd=%h cnt=%0d emp=%b ovf=%b exp rd=0 cnt=0 emp=1 ovf=0",
                  pop_data, fill_count, is_empty, overflow);
      end
      rst_n = 1'b1;

      op(1, 0, '0, "R6", 1);                     // read while empty
      for (int i = 0; i < CAP; i++) op(0, 1, DW'(16'hA100 + i), "R2", 1);
      op(0, 1, 16'hDEAD, "R3", 1);               // full: dropped
      op(0, 1, 16'hBEEF, "R3", 1);
      op(1, 1, 16'hC0DE, "R8", 1);               // full: read then write accepted
      for (int i = 0; i < 3; i++) op(1, 0, '0, "R4", 1);
      op(1, 1, 16'h5A5A, "R8", 1);               // partly filled
      for (int i = 0; i < CAP; i++) op(1, 0, '0, "R9", 1);  // drain in order
      op(1, 0, '0, "R5", 1);
      op(1, 0, '0, "R6", 1);
      op(0, 1, 16'h1111, "R7", 3);               // held write acts once
      op(1, 0, '0, "R7", 3);                     // held read acts once
      op(1, 1, 16'h2222, "R8", 1);               // empty: no word out, word stored
      op(1, 0, '0, "R4", 1);
      op(0, 1, 16'h3333, "R2", 1);
      op(0, 1, 16'h4444, "R2", 1);
      op(1, 0, '0, "R9", 1);
      op(1, 0, '0, "R5", 1);

      repeat (3) @(negedge clk);
      report();
      $finish;
   end
endmodule